// File: doc/BRIEF.md
# Dual-Channel Pattern Control Registers

This block is the register and interrupt front end for a pair of serial pattern channels. Software reaches it over a simple single-cycle bus. Each access carries a byte address, a write enable and a 32-bit write word. Read data is returned combinationally from the addressed word, with no wait states. The block holds one control word, a divide ratio for each channel, a 64-bit pattern for each channel, and one shared size word that packs pattern length and repeat count for both channels. It drives these values straight to two channel sequencers, which sit outside this block.

The block also collects the sequencers' completion pulses into sticky interrupt status bits. Each status bit is cleared by writing one to it. Each status bit is gated onto its interrupt line by an enable bit. A separate test register lets software raise a status bit on its own.

While a channel is enabled, its configuration is frozen: bus writes to its polarity, ratio, pattern and size fields are dropped. The channel's enable bit itself can always be written. Setting both enable bits in one write starts both channels on the same clock.

Top module: `pcr_regs`

## Requirements
- R1: After reset every register reads zero, both enable and polarity outputs are low, all configuration outputs are zero and both interrupt lines are low.
- R2: Word offsets are: status 0x0, interrupt enable 0x4, test 0x8, control 0xC, channel 0 ratio 0x10, channel 1 ratio 0x14, channel 0 pattern 0x18/0x1C, channel 1 pattern 0x20/0x24, size 0x28. A channel's ratio and pattern read back what was written while that channel is disabled, and they appear on the channel's outputs.
- R3: Control bit 0 enables channel 0, bit 1 enables channel 1, bit 2 is channel 0 polarity and bit 3 is channel 1 polarity. Each bit drives its output from the cycle after the write.
- R4: Size word fields: bits 5:0 are channel 0 length-minus-one, bits 15:6 channel 0 repeats-minus-one, bits 21:16 channel 1 length-minus-one and bits 31:22 channel 1 repeats-minus-one.
- R5: The lower pattern offset of each channel supplies pattern bits 31:0 and the upper offset supplies bits 63:32.
- R6: A write to a channel's polarity, ratio, pattern or size field is dropped if that channel was enabled before the write. Reads return the held values. The other channel's fields in the same word still update.
- R7: Enable bits are always writable. A control write with bits 1:0 = 11 raises both enable outputs on the same cycle.
- R8: A done pulse on channel k sets status bit k (bit 0 for channel 0, bit 1 for channel 1), and the bit stays set until cleared.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: If a done pulse and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R11: Writing 1 to test register bit k sets status bit k. The test register always reads zero.
- R12: Interrupt line k is high exactly when status bit k and interrupt-enable bit k (offset 0x4, bit k) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | ADDR_W (6) | Byte address of the access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word |
| ch_done_i | input | 2 | Completion pulses from the sequencers, one bit per channel |
| ch_enable_o | output | 2 | Channel enables |
| ch_polarity_o | output | 2 | Channel clock polarity |
| ch0_ratio_o | output | 32 | Channel 0 divide ratio |
| ch1_ratio_o | output | 32 | Channel 1 divide ratio |
| ch0_pattern_o | output | 64 | Channel 0 pattern |
| ch1_pattern_o | output | 64 | Channel 1 pattern |
| ch0_len_o | output | 6 | Channel 0 length minus one |
| ch1_len_o | output | 6 | Channel 1 length minus one |
| ch0_reps_o | output | 10 | Channel 0 repeats minus one |
| ch1_reps_o | output | 10 | Channel 1 repeats minus one |
| irq_o | output | 2 | Interrupt lines, one per channel |

## Verification
The bench builds the block with its default address width of six bits, which covers the whole register map including the size word at 0x28. At this width every offset can be reached, and the bench writes full 32-bit patterns that tell the two channels' fields in the shared size and control words apart. This exposes the partial update of a word in which one channel is frozen and the other is free. Done pulses are driven directly, so the same-cycle collision between a completion and a clearing write can be placed on an exact edge.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
    localparam int BUS_W = 32;
    localparam int PAT_W = 2 * BUS_W;
    localparam int LEN_W = 6;
    localparam int REP_W = 10;
    localparam int NCH   = 2;
    localparam int SZ_W  = LEN_W + REP_W;

    // word indices (byte offset / 4)
    localparam int IDX_STAT  = 0;
    localparam int IDX_IEN   = 1;
    localparam int IDX_TEST  = 2;
    localparam int IDX_CTRL  = 3;
    localparam int IDX_DIV0  = 4;
    localparam int IDX_PAT0  = 6;
    localparam int IDX_SIZE  = 10;

    typedef struct packed {
        logic             pol;
        logic [BUS_W-1:0] ratio;
        logic [PAT_W-1:0] pat;
        logic [LEN_W-1:0] len;
        logic [REP_W-1:0] reps;
    } chan_cfg_t;

    typedef struct packed {
        logic [NCH-1:0] stat;
        logic [NCH-1:0] ien;
    } irq_regs_t;
endpackage

// File: rtl/pcr_chan_cfg.sv
module pcr_chan_cfg
    import pcr_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             wr_ctrl_i,
    input  logic             wr_div_i,
    input  logic             wr_pat_lo_i,
    input  logic             wr_pat_hi_i,
    input  logic             wr_size_i,
    input  logic [BUS_W-1:0] wdata_i,
    output chan_cfg_t        cfg_o
);
    localparam int POL_BIT = NCH + CH;
    localparam int SZ_LO   = CH * SZ_W;

    chan_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!en_i) begin
            if (wr_ctrl_i)   cfg_d.pol = wdata_i[POL_BIT];
            if (wr_div_i)    cfg_d.ratio = wdata_i;
            if (wr_pat_lo_i) cfg_d.pat[BUS_W-1:0] = wdata_i;
            if (wr_pat_hi_i) cfg_d.pat[PAT_W-1:BUS_W] = wdata_i;
            if (wr_size_i) begin
                cfg_d.len  = wdata_i[SZ_LO +: LEN_W];
                cfg_d.reps = wdata_i[SZ_LO + LEN_W +: REP_W];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R6
    frozen_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> $stable(cfg_q));
endmodule

// File: rtl/pcr_irq.sv
module pcr_irq
    import pcr_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] done_i,
    input  logic           wr_stat_i,
    input  logic           wr_ien_i,
    input  logic           wr_test_i,
    input  logic [NCH-1:0] wdata_i,
    output logic [NCH-1:0] stat_o,
    output logic [NCH-1:0] ien_o,
    output logic [NCH-1:0] irq_o
);
    irq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_stat_i) r_d.stat = r_d.stat & ~wdata_i;
        if (wr_test_i) r_d.stat = r_d.stat | wdata_i;
        r_d.stat = r_d.stat | done_i;
        if (wr_ien_i)  r_d.ien = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign stat_o = r_q.stat;
    assign ien_o  = r_q.ien;
    assign irq_o  = r_q.stat & r_q.ien;

    // R8 R10
    done_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|done_i) |=> ((r_q.stat & $past(done_i)) == $past(done_i)));

    // R9
    w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_stat_i |=> ((r_q.stat & $past(wdata_i & ~done_i)) == '0));

    // R8
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_stat_i |=> ((r_q.stat & $past(r_q.stat)) == $past(r_q.stat)));
endmodule

// File: rtl/pcr_regs.sv
module pcr_regs
    import pcr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic [1:0]        ch_done_i,
    output logic [1:0]        ch_enable_o,
    output logic [1:0]        ch_polarity_o,
    output logic [31:0]       ch0_ratio_o,
    output logic [31:0]       ch1_ratio_o,
    output logic [63:0]       ch0_pattern_o,
    output logic [63:0]       ch1_pattern_o,
    output logic [5:0]        ch0_len_o,
    output logic [5:0]        ch1_len_o,
    output logic [9:0]        ch0_reps_o,
    output logic [9:0]        ch1_reps_o,
    output logic [1:0]        irq_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic [NCH-1:0]   en_d, en_q;
    logic [NCH-1:0]   stat, ien;
    chan_cfg_t        cfg [NCH];

    assign idx     = bus_addr_i[ADDR_W-1:2];
    assign aligned = (bus_addr_i[1:0] == 2'b00);

    function automatic logic hit(input logic [IDX_W-1:0] i, input int target);
        return aligned && (int'(i) == target);
    endfunction

    always_comb begin
        en_d = en_q;
        if (bus_we_i && hit(idx, IDX_CTRL)) en_d = bus_wdata_i[NCH-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= '0;
        else         en_q <= en_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pcr_chan_cfg #(.CH(c)) u_cfg (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .en_i        (en_q[c]),
            .wr_ctrl_i   (bus_we_i && hit(idx, IDX_CTRL)),
            .wr_div_i    (bus_we_i && hit(idx, IDX_DIV0 + c)),
            .wr_pat_lo_i (bus_we_i && hit(idx, IDX_PAT0 + 2 * c)),
            .wr_pat_hi_i (bus_we_i && hit(idx, IDX_PAT0 + 2 * c + 1)),
            .wr_size_i   (bus_we_i && hit(idx, IDX_SIZE)),
            .wdata_i     (bus_wdata_i),
            .cfg_o       (cfg[c])
        );
        assign ch_polarity_o[c] = cfg[c].pol;
    end

    pcr_irq u_irq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .done_i    (ch_done_i),
        .wr_stat_i (bus_we_i && hit(idx, IDX_STAT)),
        .wr_ien_i  (bus_we_i && hit(idx, IDX_IEN)),
        .wr_test_i (bus_we_i && hit(idx, IDX_TEST)),
        .wdata_i   (bus_wdata_i[NCH-1:0]),
        .stat_o    (stat),
        .ien_o     (ien),
        .irq_o     (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (aligned) begin
            case (int'(idx))
                IDX_STAT:         bus_rdata_o[NCH-1:0] = stat;
                IDX_IEN:          bus_rdata_o[NCH-1:0] = ien;
                IDX_CTRL:         bus_rdata_o[2*NCH-1:0] = {ch_polarity_o, en_q};
                IDX_DIV0:         bus_rdata_o = cfg[0].ratio;
                IDX_DIV0 + 1:     bus_rdata_o = cfg[1].ratio;
                IDX_PAT0:         bus_rdata_o = cfg[0].pat[BUS_W-1:0];
                IDX_PAT0 + 1:     bus_rdata_o = cfg[0].pat[PAT_W-1:BUS_W];
                IDX_PAT0 + 2:     bus_rdata_o = cfg[1].pat[BUS_W-1:0];
                IDX_PAT0 + 3:     bus_rdata_o = cfg[1].pat[PAT_W-1:BUS_W];
                IDX_SIZE:         bus_rdata_o = {cfg[1].reps, cfg[1].len,
                                                 cfg[0].reps, cfg[0].len};
                default:          bus_rdata_o = '0;
            endcase
        end
    end

    assign ch_enable_o   = en_q;
    assign ch0_ratio_o   = cfg[0].ratio;
    assign ch1_ratio_o   = cfg[1].ratio;
    assign ch0_pattern_o = cfg[0].pat;
    assign ch1_pattern_o = cfg[1].pat;
    assign ch0_len_o     = cfg[0].len;
    assign ch1_len_o     = cfg[1].len;
    assign ch0_reps_o    = cfg[0].reps;
    assign ch1_reps_o    = cfg[1].reps;

    // R7
    dual_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && hit(idx, IDX_CTRL) && bus_wdata_i[1:0] == 2'b11)
        |=> (ch_enable_o == 2'b11));

    // R11
    test_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit(idx, IDX_TEST) |-> (bus_rdata_o == '0));
endmodule

// File: tb/pcr_regs_test.sv
module pcr_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  done = '0;
    logic [1:0]  en, pol, irq;
    logic [31:0] r0, r1;
    logic [63:0] p0, p1;
    logic [5:0]  l0, l1;
    logic [9:0]  n0, n1;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pcr_regs uut (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ch_done_i(done),
        .ch_enable_o(en), .ch_polarity_o(pol), .ch0_ratio_o(r0), .ch1_ratio_o(r1),
        .ch0_pattern_o(p0), .ch1_pattern_o(p1), .ch0_len_o(l0), .ch1_len_o(l1),
        .ch0_reps_o(n0), .ch1_reps_o(n1), .irq_o(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic pulse_done(input logic [1:0] d);
        @(negedge clk);
        done = d;
        @(negedge clk);
        done = '0;
    endtask

    task automatic t_reset;
        for (int i = 0; i <= 10; i++) rd_check("R1 reg", 6'(i * 4), 32'h0);
        check("R1 enable", en, 0);
        check("R1 polarity", pol, 0);
        check("R1 irq", irq, 0);
        check("R1 cfg", {r0, r1, l0, n1}, 0);
    endtask

    task automatic t_map;
        logic [31:0] sz;
        sz = 32'hABCD_1234;
        wr(6'h10, 32'h1234_5678);
        wr(6'h14, 32'h9ABC_DEF0);
        wr(6'h18, 32'h0BAD_F00D);
        wr(6'h1C, 32'hCAFE_0001);
        wr(6'h20, 32'h5555_AAAA);
        wr(6'h24, 32'h0F0F_F0F0);
        wr(6'h28, sz);
        check("R2 ratio0", r0, 32'h1234_5678);
        check("R2 ratio1", r1, 32'h9ABC_DEF0);
        rd_check("R2 rd ratio0", 6'h10, 32'h1234_5678);
        rd_check("R2 rd pat1 hi", 6'h24, 32'h0F0F_F0F0);
        check("R5 pattern0", p0, 64'hCAFE_0001_0BAD_F00D);
        check("R5 pattern1", p1, 64'h0F0F_F0F0_5555_AAAA);
        check("R4 len0", l0, sz[5:0]);
        check("R4 reps0", n0, sz[15:6]);
        check("R4 len1", l1, sz[21:16]);
        check("R4 reps1", n1, sz[31:22]);
        rd_check("R4 size rd", 6'h28, sz);
    endtask

    task automatic t_ctrl;
        wr(6'h0C, 32'h0000_0008);
        check("R3 pol1 only", pol, 2'b10);
        check("R3 no enable", en, 2'b00);
        wr(6'h0C, 32'h0000_0004);
        check("R3 pol0 only", pol, 2'b01);
        rd_check("R3 ctrl rd", 6'h0C, 32'h4);
        wr(6'h0C, 32'h0);
    endtask

    task automatic t_block;
        wr(6'h0C, 32'h1);
        check("R7 ch0 enabled", en, 2'b01);
        wr(6'h10, 32'hDEAD_0000);
        wr(6'h14, 32'h0000_BEEF);
        wr(6'h18, 32'hFFFF_FFFF);
        wr(6'h28, 32'h0000_0000);
        wr(6'h0C, 32'h9);
        check("R6 ratio0 held", r0, 32'h1234_5678);
        check("R6 ratio1 free", r1, 32'h0000_BEEF);
        check("R6 pattern0 held", p0, 64'hCAFE_0001_0BAD_F00D);
        rd_check("R6 size partial", 6'h28, 32'h0000_1234);
        check("R6 pol0 held pol1 set", pol, 2'b10);
        rd_check("R6 rd ratio0", 6'h10, 32'h1234_5678);
        wr(6'h0C, 32'h0);
        wr(6'h10, 32'hDEAD_0000);
        check("R6 ratio0 after disable", r0, 32'hDEAD_0000);
    endtask

    task automatic t_dual;
        wr(6'h0C, 32'h3);
        check("R7 both start", en, 2'b11);
        wr(6'h14, 32'h7777_7777);
        check("R6 ratio1 held", r1, 32'h0000_BEEF);
        wr(6'h0C, 32'h0);
        check("R7 both stop", en, 2'b00);
    endtask

    task automatic t_irq;
        wr(6'h04, 32'h3);
        pulse_done(2'b01);
        rd_check("R8 ch0 done", 6'h00, 32'h1);
        check("R12 irq0", irq, 2'b01);
        pulse_done(2'b10);
        rd_check("R8 ch1 done", 6'h00, 32'h3);
        wr(6'h00, 32'h1);
        rd_check("R9 clear bit0", 6'h00, 32'h2);
        wr(6'h00, 32'h0);
        rd_check("R9 zero no effect", 6'h00, 32'h2);
        wr(6'h00, 32'h2);
        rd_check("R9 clear bit1", 6'h00, 32'h0);
        check("R12 irq clear", irq, 2'b00);
    endtask

    task automatic t_setwins;
        @(negedge clk);
        addr = 6'h00; wdata = 32'h3; we = 1'b1; done = 2'b01;
        @(negedge clk);
        we = 1'b0; done = 2'b00;
        rd_check("R10 set wins", 6'h00, 32'h1);
        wr(6'h00, 32'h1);
    endtask

    task automatic t_test;
        wr(6'h08, 32'h2);
        rd_check("R11 test sets", 6'h00, 32'h2);
        rd_check("R11 test reads zero", 6'h08, 32'h0);
        wr(6'h00, 32'h3);
    endtask

    task automatic t_mask;
        wr(6'h04, 32'h1);
        wr(6'h08, 32'h3);
        check("R12 masked", irq, 2'b01);
        wr(6'h04, 32'h0);
        check("R12 all masked", irq, 2'b00);
        rd_check("R12 status kept", 6'h00, 32'h3);
        wr(6'h04, 32'h2);
        check("R12 ch1 only", irq, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_ctrl();
        t_block();
        t_dual();
        t_irq();
        t_setwins();
        t_test();
        t_mask();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule